// File: doc/BRIEF.md
# Dual-Form LFSR Pattern Generator

This block is a pseudo-random pattern source for built-in self-test. A linear feedback shift register advances by one state on each clock in which the step enable is high. A compile-time parameter picks one of two feedback forms. The first is an 8-stage register whose feedback XOR sits outside the chain, with polynomial x^8+x^7+x^2+1. The second is a 3-stage register whose XOR sits between stages, with polynomial x^3+x+1. The current state is presented in parallel on every cycle, with stage xi on pattern bit i, so it can drive the inputs of a circuit under test.

A synchronous load copies a seed into the register and takes priority over stepping. In the 3-stage form, a second parameter can place an inverter on the x1 output. That remaps the pattern set so that 010 is never shown and 000 is shown in its place. Next to the plain bits, four weighted outputs give signals whose probability of being 1 is about 1/2, 1/4, 1/8 and 1/16. Each one is the AND of the 1, 2, 3 or 4 most significant pattern bits.

Top module: `lfsr_pattern_gen`

## Requirements
- R1: After reset the register holds x0=1 with every other stage 0. The pattern is 8'h01 in both forms, or 8'h03 in the 3-stage form with remap.
- R2: In the 8-stage form a step makes the new x7 equal to x7^x2^x0, and every other stage xi takes the old x(i+1). From 8'h01 the patterns are 80, C0, E0, F0, F8, FC, 7E.
- R3: In the 3-stage form a step gives new x0 = old x2, new x1 = old x0^x2 and new x2 = old x1. From x0=1 it visits all seven nonzero states and returns to the start after exactly 7 steps.
- R4: When load is high at a clock edge, the register takes the seed after that edge whatever the step enable is. The 3-stage form keeps only seed bits [2:0].
- R5: When load and step are both low, the register and all outputs hold their values.
- R6: With remap on in the 3-stage form, pattern bit 1 is the inverse of x1. Over one period the patterns seen are every 3-bit value except 010, and 000 is among them.
- R7: Weighted output k (k=0..3) is the AND of pattern bits 7 down to 7-k. In the 3-stage form all four are 0.
- R8: An all-zero seed locks either form at zero while stepping. With remap on, the 3-stage pattern then reads 010.
- R9: In the 3-stage form pattern bits 7..3 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadIn | input | 1 | Load seed on this edge |
| stepIn | input | 1 | Advance one state on this edge |
| seedIn | input | 8 | Seed value, stage xi on bit i |
| patternOut | output | 8 | Parallel pattern, stage xi on bit i |
| weightOut | output | 4 | Weighted outputs, bit k = AND of top k+1 pattern bits |

## Verification
The in-line assertions check on every cycle that load beats step, that an idle cycle holds the state, that a nonzero state never steps to zero, that the remapped pattern never shows 010 while the register is nonzero, and that the weighted outputs nest. Only the bench scenarios can show the exact state sequences of both polynomials, the 7-step period and full coverage of the 3-stage form, the pattern set produced under remap, and the lock-up behaviour of a zero seed.

// File: rtl/lfsr_pattern_pkg.sv
package lfsr_pattern_pkg;

  typedef enum logic {
    FORM_EXTERNAL = 1'b0,
    FORM_INTERNAL = 1'b1
  } lfsrForm_t;

  localparam int PAT_W    = 8;
  localparam int WEIGHT_N = 4;

  typedef struct packed {
    logic loadStb;
    logic stepStb;
  } lfsrStrobe_t;

  function automatic int stateWidth(lfsrForm_t form);
    return (form == FORM_EXTERNAL) ? 8 : 3;
  endfunction

endpackage

// File: rtl/lfsr_ctrl.sv
module lfsr_ctrl
  import lfsr_pattern_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadIn,
  input  logic        stepIn,
  output lfsrStrobe_t strobes
);

  always_comb begin
    strobes.loadStb = loadIn;
    strobes.stepStb = stepIn & ~loadIn;
  end

  // Load has priority over step.
  p_load_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    loadIn |-> !strobes.stepStb);

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.loadStb, strobes.stepStb}));

endmodule

// File: rtl/lfsr_datapath.sv
module lfsr_datapath
  import lfsr_pattern_pkg::*;
#(
  parameter lfsrForm_t FORM    = FORM_EXTERNAL,
  parameter int        STATE_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  lfsrStrobe_t        strobes,
  input  logic [STATE_W-1:0] seedIn,
  output logic [STATE_W-1:0] stateOut
);

  localparam logic [STATE_W-1:0] RESET_STATE = STATE_W'(1);

  logic [STATE_W-1:0] stateQ;
  logic [STATE_W-1:0] stateNext;

  generate
    if (FORM == FORM_EXTERNAL) begin : g_external
      // XOR network outside the chain; shift toward x0.
      always_comb begin
        stateNext = {stateQ[7] ^ stateQ[2] ^ stateQ[0], stateQ[STATE_W-1:1]};
      end
    end else begin : g_internal
      // XOR between stages; feedback from x2.
      always_comb begin
        stateNext[0] = stateQ[2];
        stateNext[1] = stateQ[0] ^ stateQ[2];
        stateNext[2] = stateQ[1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= RESET_STATE;
    end else if (strobes.loadStb) begin
      stateQ <= seedIn;
    end else if (strobes.stepStb) begin
      stateQ <= stateNext;
    end
  end

  assign stateOut = stateQ;

  p_seed_taken_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadStb |=> stateQ == $past(seedIn));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.loadStb && !strobes.stepStb) |=> $stable(stateQ));

  p_no_zero_entry_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stepStb && stateQ != '0) |=> stateQ != '0);

  p_zero_lock_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stepStb && stateQ == '0) |=> stateQ == '0);

endmodule

// File: rtl/lfsr_pattern_map.sv
module lfsr_pattern_map
  import lfsr_pattern_pkg::*;
#(
  parameter lfsrForm_t FORM     = FORM_EXTERNAL,
  parameter int        STATE_W  = 8,
  parameter bit        REMAP_EN = 1'b0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [STATE_W-1:0] stateIn,
  output logic [PAT_W-1:0]   patternOut,
  output logic [WEIGHT_N-1:0] weightOut
);

  generate
    if (FORM == FORM_EXTERNAL) begin : g_ext_map
      assign patternOut = stateIn;
    end else begin : g_int_map
      logic remapBit;
      assign remapBit   = REMAP_EN ? ~stateIn[1] : stateIn[1];
      assign patternOut = {{(PAT_W-3){1'b0}}, stateIn[2], remapBit, stateIn[0]};

      if (REMAP_EN) begin : g_remap_chk
        p_no_010_r6: assert property (@(posedge clk) disable iff (!rstN)
          (stateIn != '0) |-> patternOut[2:0] != 3'b010);
      end

      p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
        patternOut[PAT_W-1:3] == '0);
    end
  endgenerate

  for (genvar k = 0; k < WEIGHT_N; k++) begin : g_weight
    assign weightOut[k] = &patternOut[PAT_W-1 -: (k+1)];
  end

  p_weight_nest_r7: assert property (@(posedge clk) disable iff (!rstN)
    weightOut[3] |-> (weightOut[2] && weightOut[1] && weightOut[0]));

endmodule

// File: rtl/lfsr_pattern_gen.sv
module lfsr_pattern_gen
  import lfsr_pattern_pkg::*;
#(
  parameter lfsrForm_t FORM     = FORM_EXTERNAL,
  parameter bit        REMAP_EN = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadIn,
  input  logic        stepIn,
  input  logic [7:0]  seedIn,
  output logic [7:0]  patternOut,
  output logic [3:0]  weightOut
);

  localparam int STATE_W = stateWidth(FORM);

  lfsrStrobe_t        strobes;
  logic [STATE_W-1:0] stateVal;

  lfsr_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .loadIn  (loadIn),
    .stepIn  (stepIn),
    .strobes (strobes)
  );

  lfsr_datapath #(.FORM(FORM), .STATE_W(STATE_W)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .seedIn   (seedIn[STATE_W-1:0]),
    .stateOut (stateVal)
  );

  lfsr_pattern_map #(.FORM(FORM), .STATE_W(STATE_W), .REMAP_EN(REMAP_EN)) i_map (
    .clk        (clk),
    .rstN       (rstN),
    .stateIn    (stateVal),
    .patternOut (patternOut),
    .weightOut  (weightOut)
  );

endmodule

// File: tb/test_lfsr_pattern_gen.sv
module test_lfsr_pattern_gen;
  import lfsr_pattern_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadIn = 1'b0;
  logic stepIn = 1'b0;
  logic [7:0] seedIn = 8'h00;
  logic [7:0] patExt, patInt, patRmp;
  logic [3:0] wExt, wInt, wRmp;

  int errors = 0;
  int checks = 0;
  logic [7:0] modelExt;
  logic [2:0] modelInt;

  always #(CLK_PERIOD/2) clk = ~clk;

  lfsr_pattern_gen #(.FORM(FORM_EXTERNAL), .REMAP_EN(1'b0)) i_lfsr_pattern_gen (
    .clk(clk), .rstN(rstN), .loadIn(loadIn), .stepIn(stepIn), .seedIn(seedIn),
    .patternOut(patExt), .weightOut(wExt));

  lfsr_pattern_gen #(.FORM(FORM_INTERNAL), .REMAP_EN(1'b0)) i_lfsr_pattern_gen_int (
    .clk(clk), .rstN(rstN), .loadIn(loadIn), .stepIn(stepIn), .seedIn(seedIn),
    .patternOut(patInt), .weightOut(wInt));

  lfsr_pattern_gen #(.FORM(FORM_INTERNAL), .REMAP_EN(1'b1)) i_lfsr_pattern_gen_rmp (
    .clk(clk), .rstN(rstN), .loadIn(loadIn), .stepIn(stepIn), .seedIn(seedIn),
    .patternOut(patRmp), .weightOut(wRmp));

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] wantWeights(input logic [7:0] p);
    return {&p[7:4], &p[7:5], &p[7:6], p[7]};
  endfunction

  // One clock with the given inputs; models follow the stated recurrences.
  task automatic tick(input logic ld, input logic st, input logic [7:0] sd);
    loadIn = ld; stepIn = st; seedIn = sd;
    @(posedge clk);
    if (ld) begin
      modelExt = sd;
      modelInt = sd[2:0];
    end else if (st) begin
      modelExt = {modelExt[7] ^ modelExt[2] ^ modelExt[0], modelExt[7:1]};
      modelInt = {modelInt[1], modelInt[0] ^ modelInt[2], modelInt[2]};
    end
    #1;
  endtask

  task automatic checkAll(input string tag);
    logic [7:0] rmpExp;
    rmpExp = {5'b0, modelInt[2], ~modelInt[1], modelInt[0]};
    chk(patExt == modelExt, {tag, " ext"}, patExt, modelExt);
    chk(patInt == {5'b0, modelInt}, {tag, " int"}, patInt, {5'b0, modelInt});
    chk(patRmp == rmpExp, {tag, " rmp"}, patRmp, rmpExp);
    chk(wExt == wantWeights(modelExt), "R7 ext weights", {4'b0, wExt}, {4'b0, wantWeights(modelExt)});
    chk(wInt == 4'b0 && wRmp == 4'b0, "R7 int weights zero", {wInt, wRmp}, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] extSeq [7];
    logic [7:0] maskInt, maskRmp;
    logic [7:0] holdExt;
    int firstReturn;
    extSeq = '{8'h80, 8'hC0, 8'hE0, 8'hF0, 8'hF8, 8'hFC, 8'h7E};
    modelExt = 8'h01;
    modelInt = 3'b001;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(patExt == 8'h01, "R1 ext reset", patExt, 8'h01);
    chk(patInt == 8'h01, "R1 int reset", patInt, 8'h01);
    chk(patRmp == 8'h03, "R1 rmp reset", patRmp, 8'h03);
    rstN = 1'b1;
    tick(1'b0, 1'b0, 8'h00);
    checkAll("R1 after release");

    // R2 listed sequence from 01
    for (int i = 0; i < 7; i++) begin
      tick(1'b0, 1'b1, 8'h00);
      chk(patExt == extSeq[i], "R2 listed sequence", patExt, extSeq[i]);
      checkAll("R2/R3 recurrence");
    end
    // R2/R3 long sweep against the models
    for (int i = 0; i < 400; i++) begin
      tick(1'b0, 1'b1, 8'h00);
      checkAll("R2/R3 sweep");
    end

    // R3 period and coverage, R6 remap set
    tick(1'b1, 1'b0, 8'h01);
    checkAll("R4 reseed");
    maskInt = 8'h00;
    maskRmp = 8'h00;
    firstReturn = 0;
    for (int i = 1; i <= 7; i++) begin
      tick(1'b0, 1'b1, 8'h00);
      maskInt[patInt[2:0]] = 1'b1;
      maskRmp[patRmp[2:0]] = 1'b1;
      if (patInt == 8'h01 && firstReturn == 0) firstReturn = i;
      chk(patRmp[2:0] != 3'b010, "R6 no 010 shown", patRmp, 8'h00);
    end
    chk(firstReturn == 7, "R3 period 7", 8'(firstReturn), 8'd7);
    chk(maskInt == 8'hFE, "R3 all nonzero visited", maskInt, 8'hFE);
    chk(maskRmp == 8'hFB, "R6 remapped set", maskRmp, 8'hFB);

    // R5 hold
    tick(1'b0, 1'b1, 8'h00);
    holdExt = patExt;
    for (int i = 0; i < 3; i++) begin
      tick(1'b0, 1'b0, 8'hFF);
      chk(patExt == holdExt, "R5 hold ext", patExt, holdExt);
      checkAll("R5 hold");
    end

    // R4 load beats step, upper seed bits dropped; R9 upper pattern bits
    tick(1'b1, 1'b1, 8'hA5);
    chk(patExt == 8'hA5, "R4 ext load priority", patExt, 8'hA5);
    chk(patInt == 8'h05, "R4 R9 int keeps low bits", patInt, 8'h05);
    chk(patRmp == 8'h07, "R4 R6 rmp after load", patRmp, 8'h07);
    checkAll("R4 load");
    tick(1'b1, 1'b1, 8'hF8);
    chk(patInt == 8'h00, "R4 R9 int upper seed ignored", patInt, 8'h00);

    // R8 zero lock-up
    tick(1'b1, 1'b0, 8'h00);
    for (int i = 0; i < 5; i++) begin
      tick(1'b0, 1'b1, 8'h00);
      chk(patExt == 8'h00, "R8 ext zero lock", patExt, 8'h00);
      chk(patInt == 8'h00, "R8 int zero lock", patInt, 8'h00);
      chk(patRmp == 8'h02, "R8 rmp zero shows 010", patRmp, 8'h02);
    end

    // R7 all-ones pattern gives every weight high
    tick(1'b1, 1'b0, 8'hFF);
    chk(wExt == 4'hF, "R7 all ones weights", {4'b0, wExt}, 8'h0F);
    tick(1'b1, 1'b0, 8'hE0);
    chk(wExt == 4'h7, "R7 three top bits", {4'b0, wExt}, 8'h07);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule